// File: doc/BRIEF.md
# Parallel NOR Flash Write-Command Decoder

This block interprets the stream of bus writes that reaches a parallel NOR flash with a 16-bit data bus. It recognises the multi-write unlock prefixes at fixed word addresses and turns each completed sequence into an action. An action is either a change of read mode (array data, identifier words or query table) or a one-cycle request to the program/erase engine. The request carries the target word address and, for a program, the data word. The storage array, the erase timing and the status bits sit outside the block. The engine reports back through a single busy input.

Read accesses are not decoded here. The block only presents the selected read mode and the two identifier words. The array, status and query paths use that selection to steer their read data. An unlock-bypass mode shortens program commands to two writes. Query mode keeps the mode it was entered from, so that leaving query mode lands back in identifier mode when that was the starting point.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, read_sel is 0 (array read), bypass_on is 0 and none of prog_req, erase_req, suspend_req or resume_req is high.
- R2: Writing 0xAA to word 0x555, then 0x55 to word 0x2AA, then 0x90 to word 0x555 sets read_sel to 1 (identifier). id_word then shows 0x00BF when id_index is 0 and 0x236D when id_index is 1.
- R3: Writing 0x98 to word 0x55 from array read or identifier mode sets read_sel to 2 (query). In query mode, 0xF0 restores the mode that was active before query entry. Every other write in query mode leaves read_sel unchanged.
- R4: In identifier mode, any write other than 0x98 to word 0x55 returns read_sel to 0. That includes 0xF0 at any address.
- R5: The unlock pair, then 0xA0 to word 0x555, arms a program. The next write raises prog_req for exactly one cycle, with prog_addr and prog_data equal to that write's address and data, whatever the data value.
- R6: The unlock pair, 0x80 to 0x555 and a second unlock pair form an erase prefix. 0x10 to 0x555 then raises erase_req with erase_all=1. 0x30 to any address raises erase_req with erase_all=0 and erase_addr equal to that address. Each request lasts one cycle.
- R7: The unlock pair, then 0x20 to 0x555, sets bypass_on. In bypass, 0xA0 at any address arms a program, and the next write raises prog_req. 0x00 clears bypass_on. All other bypass writes are ignored, and a bare 0xA0 after leaving bypass arms nothing.
- R8: Only the low 11 address bits take part in matching the command addresses 0x555, 0x2AA and 0x55. For example, 0x5555 and 0x2AAA complete an unlock.
- R9: A write that does not fit the expected next step of a sequence discards the partial sequence and leaves array read mode. A later complete sequence is accepted normally.
- R10: While engine_busy is high, writes change neither read_sel nor bypass_on and raise neither prog_req nor erase_req. A command byte of 0xB0 raises suspend_req and 0x30 raises resume_req, each for one cycle.
- R11: At most one of prog_req, erase_req, suspend_req and resume_req is high in any cycle. Commands are taken from the low data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data; commands use bits 7:0 |
| engine_busy | input | 1 | Program/erase engine is working |
| id_index | input | 1 | Selects identifier word 0 or 1 |
| read_sel | output | 2 | 0 array, 1 identifier, 2 query |
| bypass_on | output | 1 | Unlock-bypass mode active |
| id_word | output | 16 | Identifier word for id_index |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target word address |
| prog_data | output | 16 | Program data word |
| erase_req | output | 1 | One-cycle erase request |
| erase_all | output | 1 | Erase request covers the whole chip |
| erase_addr | output | ADDR_W | Sector address of a sector erase |
| suspend_req | output | 1 | One-cycle erase-suspend request |
| resume_req | output | 1 | One-cycle erase-resume request |

## Verification
The checker watches invariants on every cycle. Request strobes never overlap and a program request never lasts two cycles. A busy engine freezes the mode and blocks program and erase requests. 0xF0 always leaves query mode, a non-query write always leaves identifier mode, and bypass always reads the array. Only the bench's scenarios show the following: the exact multi-write sequences and the addresses and data carried by each request, the return from query mode to identifier mode, the masking of the upper address bits, the recovery after a broken prefix, and the fact that a bare 0xA0 after leaving bypass arms nothing.

// File: rtl/nfcd_pkg.sv
package nfcd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_IDENT = 2'd1,
    RD_QUERY = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_UNL1 = 3'd1,
    SQ_UNL2 = 3'd2,
    SQ_PROG = 3'd3,
    SQ_ERA1 = 3'd4,
    SQ_ERA2 = 3'd5,
    SQ_ERA3 = 3'd6
  } seq_e;

  localparam logic [7:0] OP_KEY_A     = 8'hAA;
  localparam logic [7:0] OP_KEY_B     = 8'h55;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_RESET     = 8'hF0;
  localparam logic [7:0] OP_PROG      = 8'hA0;
  localparam logic [7:0] OP_ERASE_PRE = 8'h80;
  localparam logic [7:0] OP_ERASE_ALL = 8'h10;
  localparam logic [7:0] OP_ERASE_SEC = 8'h30;
  localparam logic [7:0] OP_BYPASS_IN = 8'h20;
  localparam logic [7:0] OP_BYPASS_EX = 8'h00;
  localparam logic [7:0] OP_SUSPEND   = 8'hB0;
  localparam logic [7:0] OP_RESUME    = 8'h30;

  typedef struct packed {
    logic ident;
    logic query;
    logic qexit;
    logic to_array;
    logic prog;
    logic erase_all;
    logic erase_sec;
    logic suspend;
    logic resume;
  } seq_ev_t;

endpackage

// File: rtl/nfcd_key_match.sv
module nfcd_key_match #(
  parameter int KEY_W = 11,
  parameter int KEY   = 'h555
) (
  input  logic [KEY_W-1:0] low_addr,
  output logic             hit
);
  localparam logic [KEY_W-1:0] KeyVal = KEY_W'(KEY);
  assign hit = (low_addr == KeyVal);
endmodule

// File: rtl/nfcd_sequencer.sv
module nfcd_sequencer
  import nfcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [7:0] cmd,
  input  logic     hit_a,
  input  logic     hit_b,
  input  logic     hit_q,
  input  logic     busy,
  input  rd_mode_e mode,
  output logic     byp_q,
  output seq_ev_t  ev
);
  seq_e seq_q, seq_d;
  logic byp_d;

  always_comb begin
    seq_d = seq_q;
    byp_d = byp_q;
    ev    = '0;
    if (wr_en) begin
      if (busy) begin
        if (cmd == OP_SUSPEND)     ev.suspend = 1'b1;
        else if (cmd == OP_RESUME) ev.resume  = 1'b1;
      end else if (mode == RD_QUERY) begin
        if (cmd == OP_RESET) ev.qexit = 1'b1;
      end else if (mode == RD_IDENT) begin
        if (cmd == OP_QUERY && hit_q) ev.query    = 1'b1;
        else                          ev.to_array = 1'b1;
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            if (byp_q) begin
              if (cmd == OP_PROG)           seq_d = SQ_PROG;
              else if (cmd == OP_BYPASS_EX) byp_d = 1'b0;
            end else if (cmd == OP_KEY_A && hit_a) begin
              seq_d = SQ_UNL1;
            end else if (cmd == OP_QUERY && hit_q) begin
              ev.query = 1'b1;
            end
          end
          SQ_UNL1: seq_d = (cmd == OP_KEY_B && hit_b) ? SQ_UNL2 : SQ_IDLE;
          SQ_UNL2: begin
            seq_d = SQ_IDLE;
            if (hit_a) begin
              case (cmd)
                OP_IDENT:     ev.ident = 1'b1;
                OP_PROG:      seq_d = SQ_PROG;
                OP_ERASE_PRE: seq_d = SQ_ERA1;
                OP_BYPASS_IN: byp_d = 1'b1;
                default:      seq_d = SQ_IDLE;
              endcase
            end
          end
          SQ_PROG: begin
            ev.prog = 1'b1;
            seq_d   = SQ_IDLE;
          end
          SQ_ERA1: seq_d = (cmd == OP_KEY_A && hit_a) ? SQ_ERA2 : SQ_IDLE;
          SQ_ERA2: seq_d = (cmd == OP_KEY_B && hit_b) ? SQ_ERA3 : SQ_IDLE;
          SQ_ERA3: begin
            seq_d = SQ_IDLE;
            if (cmd == OP_ERASE_ALL && hit_a) ev.erase_all = 1'b1;
            else if (cmd == OP_ERASE_SEC)     ev.erase_sec = 1'b1;
          end
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      byp_q <= 1'b0;
    end else begin
      seq_q <= seq_d;
      byp_q <= byp_d;
    end
  end
endmodule

// File: rtl/nfcd_mode_reg.sv
module nfcd_mode_reg
  import nfcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  seq_ev_t  ev,
  output rd_mode_e mode_q
);
  rd_mode_e mode_d, ret_q, ret_d;

  always_comb begin
    mode_d = mode_q;
    ret_d  = ret_q;
    if (ev.ident) begin
      mode_d = RD_IDENT;
    end else if (ev.query) begin
      ret_d  = mode_q;
      mode_d = RD_QUERY;
    end else if (ev.qexit) begin
      mode_d = ret_q;
    end else if (ev.to_array) begin
      mode_d = RD_ARRAY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RD_ARRAY;
      ret_q  <= RD_ARRAY;
    end else begin
      mode_q <= mode_d;
      ret_q  <= ret_d;
    end
  end
endmodule

// File: rtl/nfcd_req_reg.sv
module nfcd_req_reg
  import nfcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ev_t           ev,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              erase_all,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              suspend_req,
  output logic              resume_req
);
  logic prog_ld, erase_ld;

  assign prog_ld  = ev.prog;
  assign erase_ld = ev.erase_all | ev.erase_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_req    <= 1'b0;
      erase_req   <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
    end else begin
      prog_req    <= prog_ld;
      erase_req   <= erase_ld;
      suspend_req <= ev.suspend;
      resume_req  <= ev.resume;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (prog_ld) begin
      prog_addr <= wr_addr;
      prog_data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_all  <= 1'b0;
      erase_addr <= '0;
    end else if (erase_ld) begin
      erase_all  <= ev.erase_all;
      erase_addr <= wr_addr;
    end
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nfcd_pkg::*;
#(
  parameter int          ADDR_W  = 22,
  parameter int          KEY_W   = 11,
  parameter int          ADDR_KA = 'h555,
  parameter int          ADDR_KB = 'h2AA,
  parameter int          ADDR_QY = 'h55,
  parameter logic [15:0] MFR_ID  = 16'h00BF,
  parameter logic [15:0] DEV_ID  = 16'h236D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              engine_busy,
  input  logic              id_index,
  output logic [1:0]        read_sel,
  output logic              bypass_on,
  output logic [15:0]       id_word,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_data,
  output logic              erase_req,
  output logic              erase_all,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              suspend_req,
  output logic              resume_req
);
  localparam int NumKeys = 3;
  localparam int KeyTab [NumKeys] = '{ADDR_KA, ADDR_KB, ADDR_QY};

  logic [1:0]         rst_sync;
  logic               rst_in_n;
  logic [NumKeys-1:0] key_hit;
  rd_mode_e           mode;
  seq_ev_t            ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  for (genvar g = 0; g < NumKeys; g++) begin : g_key
    nfcd_key_match #(.KEY_W(KEY_W), .KEY(KeyTab[g])) u_match (
      .low_addr (wr_addr[KEY_W-1:0]),
      .hit      (key_hit[g])
    );
  end

  nfcd_sequencer u_seq (
    .clk   (clk),
    .rst_n (rst_in_n),
    .wr_en (wr_en),
    .cmd   (wr_data[7:0]),
    .hit_a (key_hit[0]),
    .hit_b (key_hit[1]),
    .hit_q (key_hit[2]),
    .busy  (engine_busy),
    .mode  (mode),
    .byp_q (bypass_on),
    .ev    (ev)
  );

  nfcd_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .ev     (ev),
    .mode_q (mode)
  );

  nfcd_req_reg #(.ADDR_W(ADDR_W), .DATA_W(16)) u_req (
    .clk         (clk),
    .rst_n       (rst_in_n),
    .ev          (ev),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .prog_req    (prog_req),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .erase_req   (erase_req),
    .erase_all   (erase_all),
    .erase_addr  (erase_addr),
    .suspend_req (suspend_req),
    .resume_req  (resume_req)
  );

  assign read_sel = mode;
  assign id_word  = id_index ? DEV_ID : MFR_ID;
endmodule

// File: rtl/nfcd_checker.sv
module nfcd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        engine_busy,
  input logic [1:0]  read_sel,
  input logic        bypass_on,
  input logic        prog_req,
  input logic        erase_req,
  input logic        suspend_req,
  input logic        resume_req
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (read_sel == 2'd0 && !bypass_on && !prog_req && !erase_req);
    end
  end

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req, suspend_req, resume_req}));

  assert_prog_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |=> $stable(read_sel) && $stable(bypass_on) && !prog_req && !erase_req);

  assert_query_leave_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (read_sel == 2'd2 && wr_en && !engine_busy && wr_data[7:0] == 8'hF0) |=> read_sel != 2'd2);

  assert_ident_leave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (read_sel == 2'd1 && wr_en && !engine_busy && wr_data[7:0] != 8'h98) |=> read_sel == 2'd0);

  assert_bypass_array_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_on |-> read_sel == 2'd0);
endmodule

bind nor_cmd_decoder nfcd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .engine_busy (engine_busy),
  .read_sel    (read_sel),
  .bypass_on   (bypass_on),
  .prog_req    (prog_req),
  .erase_req   (erase_req),
  .suspend_req (suspend_req),
  .resume_req  (resume_req)
);

// File: tb/nor_cmd_decoder_bench.sv
`timescale 1ns/1ps
module nor_cmd_decoder_bench;
  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          engine_busy = 1'b0;
  logic          id_index = 1'b0;
  logic [1:0]    read_sel;
  logic          bypass_on;
  logic [15:0]   id_word;
  logic          prog_req, erase_req, erase_all, suspend_req, resume_req;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [15:0]   prog_data;

  typedef struct packed {
    logic [2:0]    k;
    logic [AW-1:0] a;
    logic [15:0]   d;
  } exp_t;
  exp_t exp_q[$];

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  nor_cmd_decoder u_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .engine_busy(engine_busy), .id_index(id_index), .read_sel(read_sel),
    .bypass_on(bypass_on), .id_word(id_word), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req),
    .erase_all(erase_all), .erase_addr(erase_addr), .suspend_req(suspend_req),
    .resume_req(resume_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
  endtask

  task automatic expect_ev(input logic [2:0] k, input logic [AW-1:0] a, input logic [15:0] d);
    exp_t e;
    e.k = k; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  // Monitor: kinds 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume
  always @(negedge clk) begin
    if (rst_n && (prog_req || erase_req || suspend_req || resume_req)) begin
      logic [2:0] k;
      exp_t e;
      k = prog_req ? 3'd1 : erase_req ? (erase_all ? 3'd3 : 3'd2) :
          suspend_req ? 3'd4 : 3'd5;
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5/R6/R7/R10 unexpected strobe actual kind=%0d expected none", k);
      end else begin
        e = exp_q.pop_front();
        if (e.k !== k) begin
          fails++;
          $display("FAIL R5/R6/R10 strobe kind actual=%0d expected=%0d", k, e.k);
        end else if (k == 3'd1 && (prog_addr !== e.a || prog_data !== e.d)) begin
          fails++;
          $display("FAIL R5 program actual=%h/%h expected=%h/%h", prog_addr, prog_data, e.a, e.d);
        end else if (k == 3'd2 && erase_addr !== e.a) begin
          fails++;
          $display("FAIL R6 sector actual=%h expected=%h", erase_addr, e.a);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 read_sel", read_sel, 0);
    chk("R1 bypass", bypass_on, 0);
    chk("R1 strobes", {prog_req, erase_req, suspend_req, resume_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 identifier mode
    unlock(); wr(22'h555, 16'h0090);
    chk("R2 ident mode", read_sel, 1);
    id_index = 1'b0; #1 chk("R2 manufacturer", id_word, 16'h00BF);
    id_index = 1'b1; #1 chk("R2 device", id_word, 16'h236D);
    // R3 query from identifier, back to identifier
    wr(22'h055, 16'h0098);
    chk("R3 query from ident", read_sel, 2);
    wr(22'h010, 16'h0012);
    chk("R3 query ignores write", read_sel, 2);
    wr(22'h000, 16'h00F0);
    chk("R3 query back to ident", read_sel, 1);
    // R4 reset leaves identifier
    wr(22'h123, 16'h00F0);
    chk("R4 ident to array", read_sel, 0);
    // R3 query from array
    wr(22'h055, 16'h0098);
    chk("R3 query from array", read_sel, 2);
    wr(22'h000, 16'h00F0);
    chk("R3 query back to array", read_sel, 0);
    // R4 other write leaves identifier
    unlock(); wr(22'h555, 16'h0090);
    wr(22'h000, 16'h0001);
    chk("R4 non-reset write", read_sel, 0);

    // R5 program
    unlock(); wr(22'h555, 16'h00A0);
    expect_ev(3'd1, 22'h01234, 16'h0055);
    wr(22'h01234, 16'h0055);
    unlock(); wr(22'h555, 16'h00A0);
    expect_ev(3'd1, 22'h00040, 16'h00F0);
    wr(22'h00040, 16'h00F0);

    // R6 sector and chip erase
    unlock(); wr(22'h555, 16'h0080); unlock();
    expect_ev(3'd2, 22'h30000, 16'h0);
    wr(22'h30000, 16'h0030);
    unlock(); wr(22'h555, 16'h0080); unlock();
    expect_ev(3'd3, 22'h0, 16'h0);
    wr(22'h555, 16'h0010);

    // R7 bypass
    unlock(); wr(22'h555, 16'h0020);
    chk("R7 bypass entered", bypass_on, 1);
    wr(22'h777, 16'h00A0);
    expect_ev(3'd1, 22'h00006, 16'h0067);
    wr(22'h00006, 16'h0067);
    wr(22'h555, 16'h0090);
    chk("R7 bypass ignores other", bypass_on, 1);
    chk("R7 bypass reads array", read_sel, 0);
    wr(22'h000, 16'h0000);
    chk("R7 bypass left", bypass_on, 0);
    wr(22'h000, 16'h00A0);
    wr(22'h008, 16'h0089);
    chk("R7 bare program ignored", read_sel, 0);

    // R8 upper address bits ignored
    wr(22'h5555, 16'h00AA); wr(22'h2AAA, 16'h0055); wr(22'h5555, 16'h0090);
    chk("R8 wide unlock", read_sel, 1);
    wr(22'h0, 16'h00F0);

    // R9 broken sequences
    wr(22'h555, 16'h00AA); wr(22'h2AB, 16'h0055); wr(22'h555, 16'h0090);
    chk("R9 broken unlock", read_sel, 0);
    unlock(); wr(22'h555, 16'h0080); wr(22'h555, 16'h00AA);
    wr(22'h000, 16'h0012); wr(22'h100, 16'h0030);
    chk("R9 broken erase", read_sel, 0);
    unlock(); wr(22'h555, 16'h0090);
    chk("R9 recovery", read_sel, 1);
    wr(22'h0, 16'h00F0);

    // R10 busy
    engine_busy = 1'b1;
    unlock(); wr(22'h555, 16'h0090);
    chk("R10 busy ignores ident", read_sel, 0);
    expect_ev(3'd4, 22'h0, 16'h0);
    wr(22'h000, 16'h00B0);
    expect_ev(3'd5, 22'h0, 16'h0);
    wr(22'h000, 16'h0030);
    unlock(); wr(22'h555, 16'h0020);
    chk("R10 busy ignores bypass", bypass_on, 0);
    engine_busy = 1'b0;
    wr(22'h555, 16'h0090);
    chk("R10 no partial kept", read_sel, 0);

    repeat (4) @(negedge clk);
    chk("R11 all strobes seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule